// File: doc/BRIEF.md
# LCD Panel Timing Output Stage

This block drives the control side of a simple LCD panel from an internal pixel-rate clock. It produces the panel pixel clock, the horizontal sync, the vertical sync, the line load pulse, the frame (alternation) signal and a 24-bit data bus. It takes pixel data and a per-pixel valid flag from an upstream fetch stage, and a set of configuration fields from a register block.

One pixel slot lasts two cycles of `clk_i`. The panel pixel clock is low in the first cycle and high in the second, so data and every control output change together on the falling edge of the panel clock, before polarity inversion. A line is `h_act_i + h_blk_i` slots long and a frame is `v_act_i + v_blk_i` lines long. All configuration fields are copied into a shadow set while the block is stopped and at each frame boundary, so a change written mid-frame takes effect only with the next frame.

A three-state controller sequences the line. The states are `ST_STOP` (idle, counters cleared), `ST_LINE_ACT` (active part of a line) and `ST_LINE_BLK` (horizontal blanking). There are four transitions. START (`ST_STOP` to `ST_LINE_ACT`) happens when `run_i` is high. ENTER_BLANK (`ST_LINE_ACT` to `ST_LINE_BLK`) happens at the end of the last active slot. NEXT_LINE (`ST_LINE_BLK` to `ST_LINE_ACT`) happens at the end of the last blanking slot, and advances or wraps the line counter. HALT (any running state to `ST_STOP`) happens when `run_i` is low.

Top module: `lcd_panel_timing`

## Requirements
- R1: When `run_i` is low the controller enters `ST_STOP` on the next clock edge. While stopped, `lcd_data_o` is 0, `lcd_fr_o` is 0, and the pixel clock, hsync, vsync and load outputs each sit at their inactive level, which equals their polarity bit. Raising `run_i` restarts at line 0, slot 0.
- R2: Each pixel slot spans two clock cycles, with the raw pixel clock low in the first. A line has `h_act_i + h_blk_i` slots and a frame has `v_act_i + v_blk_i` lines; all four lengths are 1 to 1023.
- R3: With `pclk_gate_i` = 0 and `stn_mode_i` = 0, the raw pixel clock is high in the second cycle of every slot.
- R4: With `pclk_gate_i` = 1, or with `stn_mode_i` = 1 whatever `pclk_gate_i` says, the raw pixel clock goes high only in slots that carry valid data.
- R5: Each output among pixel clock, hsync, vsync and load has a polarity bit. Bit = 0 drives the raw signal (active high, panel clock used on its rising edge); bit = 1 drives its inverse.
- R6: Hsync is active for exactly one slot per line: the first blanking slot (slot index `h_act_i`). This holds on every line, blank lines included.
- R7: Vsync is active on lines `v_act_i` through `v_act_i + w - 1`, limited to the end of the frame. The width w comes from `vs_width_i`: 00 gives 1 line, 01 gives 2, 10 gives 3, and 11 (reserved) gives 1.
- R8: With `ld_valid_mode_i` = 0, load is active for `ld_width_i` slots starting at slot `h_act_i`, cut off at the end of the line. A width of 0 gives no pulse.
- R9: With `ld_valid_mode_i` = 1, load is active exactly in the slots that carry valid data.
- R10: A slot carries valid data when it lies in an active slot of an active line and `pix_vld_i` was high at the clock edge that opened the slot. Such a slot outputs the `pix_data_i` captured at that edge; every other slot outputs 0.
- R11: With `data_zero_i` = 1, all 24 data bits are 0 even in valid slots.
- R12: The frame signal starts at 0 and inverts at the start of the first vsync line (line `v_act_i`, slot 0), once per frame.
- R13: A configuration change made while running takes no effect until the first slot of the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal pixel-rate clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Start (1) or stop (0) the timing generator |
| stn_mode_i | input | 1 | Panel type: 1 selects STN, 0 selects TFT |
| pclk_gate_i | input | 1 | Pixel clock only during valid data (1) or free-running (0) |
| pclk_pol_i | input | 1 | Pixel clock polarity |
| hs_pol_i | input | 1 | Hsync polarity |
| vs_pol_i | input | 1 | Vsync polarity |
| ld_pol_i | input | 1 | Load polarity |
| vs_width_i | input | 2 | Vsync width code in lines |
| data_zero_i | input | 1 | Force data outputs to zero |
| ld_valid_mode_i | input | 1 | Load pulse follows valid data (1) or programmed width (0) |
| ld_width_i | input | 8 | Load pulse width in slots |
| h_act_i | input | 10 | Active slots per line |
| h_blk_i | input | 10 | Blanking slots per line |
| v_act_i | input | 10 | Active lines per frame |
| v_blk_i | input | 10 | Blanking lines per frame |
| pix_vld_i | input | 1 | Upstream pixel valid |
| pix_data_i | input | PIX_W | Upstream pixel data |
| lcd_pclk_o | output | 1 | Panel pixel clock |
| lcd_hs_o | output | 1 | Panel horizontal sync |
| lcd_vs_o | output | 1 | Panel vertical sync |
| lcd_ld_o | output | 1 | Panel line load |
| lcd_fr_o | output | 1 | Panel frame alternation signal |
| lcd_data_o | output | PIX_W | Panel pixel data |

## Verification
The collision that matters is a frame boundary. On that edge the controller takes NEXT_LINE with a line wrap, the shadow configuration reloads, and the vsync and load windows of the final blank line close, all in the same cycle. The bench writes new polarity, width and mode values at the falling edge just before that wrap. Its model samples the configuration only when it opens slot 0 of line 0, so the final slot of the old frame must still show the old polarities and the first slot of the new frame the new ones. A second run changes hsync polarity ten slots into a frame, and every later slot of that frame is judged against the old value. The restarted short-frame run adds another case: a vsync window that would extend past the last line, checked for truncation while the frame signal inverts on the same line.

// File: rtl/lcd_tim_pkg.sv
package lcd_tim_pkg;

    localparam int CNT_W = 10;
    localparam int POS_W = CNT_W + 1;
    localparam int LDW_W = 8;
    localparam int VSW_W = 2;

    typedef enum logic [1:0] {
        ST_STOP     = 2'd0,
        ST_LINE_ACT = 2'd1,
        ST_LINE_BLK = 2'd2
    } lcd_state_e;

    typedef struct packed {
        logic             stn;
        logic             gate_clk;
        logic             pol_pclk;
        logic             pol_hs;
        logic             pol_vs;
        logic             pol_ld;
        logic [VSW_W-1:0] vs_width;
        logic             data_zero;
        logic             ld_valid_mode;
        logic [LDW_W-1:0] ld_width;
        logic [CNT_W-1:0] h_act;
        logic [CNT_W-1:0] h_blk;
        logic [CNT_W-1:0] v_act;
        logic [CNT_W-1:0] v_blk;
    } lcd_cfg_t;

endpackage

// File: rtl/lcd_cfg_shadow.sv
module lcd_cfg_shadow
    import lcd_tim_pkg::*;
(
    input  logic     clk_i,
    input  logic     rst_ni,
    input  logic     load_i,
    input  lcd_cfg_t cfg_i,
    output lcd_cfg_t cfg_o
);

    lcd_cfg_t cfg_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cfg_q <= '0;
        end else if (load_i) begin
            cfg_q <= cfg_i;
        end
    end

    assign cfg_o = cfg_q;

endmodule

// File: rtl/lcd_tim_fsm.sv
module lcd_tim_fsm
    import lcd_tim_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  lcd_cfg_t         cfg_i,
    output lcd_state_e       state_o,
    output logic             phase_o,
    output logic [POS_W-1:0] hpos_o,
    output logic [POS_W-1:0] vpos_o,
    output logic             slot_adv_o,
    output logic             frame_load_o,
    output logic             fr_flip_o
);

    lcd_state_e       state_q, state_d;
    logic             phase_q;
    logic [POS_W-1:0] hpos_q, vpos_q;
    logic [POS_W-1:0] h_act_x, v_act_x, h_end, v_end;
    logic             h_last, v_last, act_last;

    assign h_act_x  = POS_W'(cfg_i.h_act);
    assign v_act_x  = POS_W'(cfg_i.v_act);
    assign h_end    = h_act_x + POS_W'(cfg_i.h_blk) - POS_W'(1);
    assign v_end    = v_act_x + POS_W'(cfg_i.v_blk) - POS_W'(1);
    assign h_last   = (hpos_q == h_end);
    assign v_last   = (vpos_q == v_end);
    assign act_last = (hpos_q == h_act_x - POS_W'(1));

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_STOP;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: START, ENTER_BLANK, NEXT_LINE, HALT
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOP: begin
                if (run_i) state_d = ST_LINE_ACT;
            end
            ST_LINE_ACT: begin
                if (!run_i)                   state_d = ST_STOP;
                else if (phase_q && act_last) state_d = ST_LINE_BLK;
            end
            ST_LINE_BLK: begin
                if (!run_i)                 state_d = ST_STOP;
                else if (phase_q && h_last) state_d = ST_LINE_ACT;
            end
            default: state_d = ST_STOP;
        endcase
    end

    // slot phase and position counters
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            phase_q <= 1'b0;
            hpos_q  <= '0;
            vpos_q  <= '0;
        end else if (!run_i || state_q == ST_STOP) begin
            phase_q <= 1'b0;
            hpos_q  <= '0;
            vpos_q  <= '0;
        end else begin
            phase_q <= ~phase_q;
            if (phase_q) begin
                if (h_last) begin
                    hpos_q <= '0;
                    vpos_q <= v_last ? '0 : vpos_q + POS_W'(1);
                end else begin
                    hpos_q <= hpos_q + POS_W'(1);
                end
            end
        end
    end

    assign state_o      = state_q;
    assign phase_o      = phase_q;
    assign hpos_o       = hpos_q;
    assign vpos_o       = vpos_q;
    assign slot_adv_o   = run_i && (state_q == ST_STOP || phase_q);
    assign frame_load_o = (state_q == ST_STOP) || (phase_q && h_last && v_last);
    assign fr_flip_o    = run_i && (state_q != ST_STOP) && phase_q && h_last
                          && (vpos_q + POS_W'(1) == v_act_x);

    AST_HALT_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_i |=> state_q == ST_STOP);                                   // R1
    AST_HPOS_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        state_q != ST_STOP |-> hpos_q <= h_end);                           // R2
    AST_VPOS_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        state_q != ST_STOP |-> vpos_q <= v_end);                           // R2
    AST_PHASE_ALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q != ST_STOP && $past(state_q) != ST_STOP)
            |-> phase_q != $past(phase_q));                               // R2

endmodule

// File: rtl/lcd_sig_gen.sv
module lcd_sig_gen
    import lcd_tim_pkg::*;
#(
    parameter int PIX_W = 24
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  lcd_state_e       state_i,
    input  logic             phase_i,
    input  logic [POS_W-1:0] hpos_i,
    input  logic [POS_W-1:0] vpos_i,
    input  logic             slot_adv_i,
    input  logic             fr_flip_i,
    input  lcd_cfg_t         cfg_i,
    input  logic             pix_vld_i,
    input  logic [PIX_W-1:0] pix_data_i,
    output logic             pclk_o,
    output logic             hs_o,
    output logic             vs_o,
    output logic             ld_o,
    output logic             fr_o,
    output logic [PIX_W-1:0] data_o
);

    localparam int VSPAN_W = POS_W + 1;

    logic             vld_q, fr_q;
    logic [PIX_W-1:0] dat_q;
    logic [POS_W-1:0] h_act_x, v_act_x, h_off;
    logic [VSPAN_W-1:0] vs_lim;
    logic [VSW_W:0]   vs_lines;
    logic running, win, dv, gate, pclk_raw, hs_act, vs_act, ld_act;

    // slot-start capture of the upstream pixel
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            vld_q <= 1'b0;
            dat_q <= '0;
        end else if (slot_adv_i) begin
            vld_q <= pix_vld_i;
            dat_q <= pix_data_i;
        end
    end

    // frame alternation
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            fr_q <= 1'b0;
        end else if (state_i == ST_STOP) begin
            fr_q <= 1'b0;
        end else if (fr_flip_i) begin
            fr_q <= ~fr_q;
        end
    end

    assign h_act_x  = POS_W'(cfg_i.h_act);
    assign v_act_x  = POS_W'(cfg_i.v_act);
    assign h_off    = hpos_i - h_act_x;
    assign vs_lines = (cfg_i.vs_width == 2'b11) ? 3'd1
                                                : {1'b0, cfg_i.vs_width} + 3'd1;
    assign vs_lim   = VSPAN_W'(v_act_x) + VSPAN_W'(vs_lines);

    // outputs
    always_comb begin
        running  = (state_i != ST_STOP);
        win      = running && (hpos_i < h_act_x) && (vpos_i < v_act_x);
        dv       = win && vld_q;
        gate     = cfg_i.stn || cfg_i.gate_clk;
        pclk_raw = running && phase_i && (!gate || dv);
        hs_act   = (state_i == ST_LINE_BLK) && (hpos_i == h_act_x);
        vs_act   = running && (vpos_i >= v_act_x) && (VSPAN_W'(vpos_i) < vs_lim);
        if (cfg_i.ld_valid_mode) begin
            ld_act = dv;
        end else begin
            ld_act = (state_i == ST_LINE_BLK) && (h_off < POS_W'(cfg_i.ld_width));
        end
        pclk_o = pclk_raw ^ cfg_i.pol_pclk;
        hs_o   = hs_act ^ cfg_i.pol_hs;
        vs_o   = vs_act ^ cfg_i.pol_vs;
        ld_o   = ld_act ^ cfg_i.pol_ld;
        fr_o   = fr_q && running;
        data_o = (dv && !cfg_i.data_zero) ? dat_q : '0;
    end

    AST_DATA_IN_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (data_o != '0) |-> (hpos_i < h_act_x && vpos_i < v_act_x));       // R10
    AST_PCLK_FIRST_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !phase_i |-> pclk_o == cfg_i.pol_pclk);                            // R2
    AST_FR_AT_VSYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fr_q != $past(fr_q) && state_i != ST_STOP && $past(state_i) != ST_STOP)
            |-> (vpos_i == v_act_x && hpos_i == '0));                      // R12
    AST_VS_OPENS_AT_VACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (vs_act && !$past(vs_act)) |-> vpos_i == v_act_x);                 // R7

endmodule

// File: rtl/lcd_panel_timing.sv
module lcd_panel_timing
    import lcd_tim_pkg::*;
#(
    parameter int PIX_W = 24
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic             stn_mode_i,
    input  logic             pclk_gate_i,
    input  logic             pclk_pol_i,
    input  logic             hs_pol_i,
    input  logic             vs_pol_i,
    input  logic             ld_pol_i,
    input  logic [1:0]       vs_width_i,
    input  logic             data_zero_i,
    input  logic             ld_valid_mode_i,
    input  logic [7:0]       ld_width_i,
    input  logic [9:0]       h_act_i,
    input  logic [9:0]       h_blk_i,
    input  logic [9:0]       v_act_i,
    input  logic [9:0]       v_blk_i,
    input  logic             pix_vld_i,
    input  logic [PIX_W-1:0] pix_data_i,
    output logic             lcd_pclk_o,
    output logic             lcd_hs_o,
    output logic             lcd_vs_o,
    output logic             lcd_ld_o,
    output logic             lcd_fr_o,
    output logic [PIX_W-1:0] lcd_data_o
);

    lcd_cfg_t         cfg_live, cfg_sh;
    lcd_state_e       state;
    logic             phase, slot_adv, frame_load, fr_flip;
    logic [POS_W-1:0] hpos, vpos;

    always_comb begin
        cfg_live               = '0;
        cfg_live.stn           = stn_mode_i;
        cfg_live.gate_clk      = pclk_gate_i;
        cfg_live.pol_pclk      = pclk_pol_i;
        cfg_live.pol_hs        = hs_pol_i;
        cfg_live.pol_vs        = vs_pol_i;
        cfg_live.pol_ld        = ld_pol_i;
        cfg_live.vs_width      = vs_width_i;
        cfg_live.data_zero     = data_zero_i;
        cfg_live.ld_valid_mode = ld_valid_mode_i;
        cfg_live.ld_width      = ld_width_i;
        cfg_live.h_act         = h_act_i;
        cfg_live.h_blk         = h_blk_i;
        cfg_live.v_act         = v_act_i;
        cfg_live.v_blk         = v_blk_i;
    end

    lcd_cfg_shadow u_shadow (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .load_i (frame_load),
        .cfg_i  (cfg_live),
        .cfg_o  (cfg_sh)
    );

    lcd_tim_fsm u_fsm (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .run_i        (run_i),
        .cfg_i        (cfg_sh),
        .state_o      (state),
        .phase_o      (phase),
        .hpos_o       (hpos),
        .vpos_o       (vpos),
        .slot_adv_o   (slot_adv),
        .frame_load_o (frame_load),
        .fr_flip_o    (fr_flip)
    );

    lcd_sig_gen #(.PIX_W(PIX_W)) u_sig (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .state_i    (state),
        .phase_i    (phase),
        .hpos_i     (hpos),
        .vpos_i     (vpos),
        .slot_adv_i (slot_adv),
        .fr_flip_i  (fr_flip),
        .cfg_i      (cfg_sh),
        .pix_vld_i  (pix_vld_i),
        .pix_data_i (pix_data_i),
        .pclk_o     (lcd_pclk_o),
        .hs_o       (lcd_hs_o),
        .vs_o       (lcd_vs_o),
        .ld_o       (lcd_ld_o),
        .fr_o       (lcd_fr_o),
        .data_o     (lcd_data_o)
    );

    AST_STOP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(!run_i) && !run_i |-> (lcd_data_o == '0 && !lcd_fr_o));     // R1

endmodule

// File: tb/lcd_panel_timing_tb_top.sv
module lcd_panel_timing_tb_top;
    import lcd_tim_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int PIX_W      = 24;

    typedef struct {
        logic pclk0, pclk1, hs, vs, ld, fr;
        logic [PIX_W-1:0] data;
        logic gate, lmode, zero, hs_hold;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run = 1'b0;
    logic pix_vld = 1'b0;
    logic [PIX_W-1:0] pix_data = '0;
    lcd_cfg_t cfg_drv;
    logic lcd_pclk, lcd_hs, lcd_vs, lcd_ld, lcd_fr;
    logic [PIX_W-1:0] lcd_data;

    int n_chk = 0;
    int n_err = 0;
    exp_t q[$];
    lcd_cfg_t m_cfg;
    int m_h = 0, m_v = 0, slot_no = 0;
    logic m_fr = 1'b0;
    logic hold_tag = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lcd_panel_timing #(.PIX_W(PIX_W)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .run_i(run),
        .stn_mode_i(cfg_drv.stn), .pclk_gate_i(cfg_drv.gate_clk),
        .pclk_pol_i(cfg_drv.pol_pclk), .hs_pol_i(cfg_drv.pol_hs),
        .vs_pol_i(cfg_drv.pol_vs), .ld_pol_i(cfg_drv.pol_ld),
        .vs_width_i(cfg_drv.vs_width), .data_zero_i(cfg_drv.data_zero),
        .ld_valid_mode_i(cfg_drv.ld_valid_mode), .ld_width_i(cfg_drv.ld_width),
        .h_act_i(cfg_drv.h_act), .h_blk_i(cfg_drv.h_blk),
        .v_act_i(cfg_drv.v_act), .v_blk_i(cfg_drv.v_blk),
        .pix_vld_i(pix_vld), .pix_data_i(pix_data),
        .lcd_pclk_o(lcd_pclk), .lcd_hs_o(lcd_hs), .lcd_vs_o(lcd_vs),
        .lcd_ld_o(lcd_ld), .lcd_fr_o(lcd_fr), .lcd_data_o(lcd_data)
    );

    task automatic chk(input logic [PIX_W-1:0] act, input logic [PIX_W-1:0] exp,
                       input string tag);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
        end
    endtask

    task automatic idle_chk(input string tag);
        chk(lcd_pclk, cfg_drv.pol_pclk, {tag, " pclk idle"});
        chk(lcd_hs,   cfg_drv.pol_hs,   {tag, " hs idle"});
        chk(lcd_vs,   cfg_drv.pol_vs,   {tag, " vs idle"});
        chk(lcd_ld,   cfg_drv.pol_ld,   {tag, " ld idle"});
        chk(lcd_fr,   1'b0,             {tag, " fr idle"});
        chk(lcd_data, '0,               {tag, " data idle"});
    endtask

    // driver: one slot per call, expected item pushed to the scoreboard
    task automatic drive_slot();
        exp_t e;
        int ha, hb, va, vb, w, lw;
        logic vld, win, dv, gate;
        logic [PIX_W-1:0] d;
        if (m_h == 0 && m_v == 0) m_cfg = cfg_drv;   // R13 frame-start sampling
        ha = int'(m_cfg.h_act); hb = int'(m_cfg.h_blk);
        va = int'(m_cfg.v_act); vb = int'(m_cfg.v_blk);
        lw = int'(m_cfg.ld_width);
        w  = (m_cfg.vs_width == 2'b11) ? 1 : int'(m_cfg.vs_width) + 1;
        if (m_h == 0 && m_v == va) m_fr = ~m_fr;
        vld = (slot_no % 3) != 2;
        d = PIX_W'(24'h5A0000 + slot_no * 7);
        slot_no++;
        pix_vld = vld; pix_data = d; run = 1'b1;
        win  = (m_h < ha) && (m_v < va);
        dv   = win && vld;
        gate = m_cfg.stn || m_cfg.gate_clk;
        e.pclk0 = m_cfg.pol_pclk;
        e.pclk1 = (gate ? dv : 1'b1) ^ m_cfg.pol_pclk;
        e.hs    = (m_h == ha) ^ m_cfg.pol_hs;
        e.vs    = ((m_v >= va) && (m_v < va + w)) ^ m_cfg.pol_vs;
        e.ld    = (m_cfg.ld_valid_mode ? dv : ((m_h >= ha) && (m_h - ha < lw)))
                  ^ m_cfg.pol_ld;
        e.fr    = m_fr;
        e.data  = (dv && !m_cfg.data_zero) ? d : '0;
        e.gate  = gate; e.lmode = m_cfg.ld_valid_mode;
        e.zero  = m_cfg.data_zero; e.hs_hold = hold_tag;
        q.push_back(e);
        m_h++;
        if (m_h == ha + hb) begin
            m_h = 0; m_v++;
            if (m_v == va + vb) m_v = 0;
        end
        @(negedge clk); @(negedge clk);
    endtask

    task automatic run_slots(input int n);
        for (int i = 0; i < n; i++) drive_slot();
    endtask

    task automatic restart();
        m_h = 0; m_v = 0; m_fr = 1'b0;
    endtask

    task automatic check_common(input exp_t e);
        chk(lcd_hs, e.hs, e.hs_hold ? "R13 hs polarity held" : "R6 hs");
        chk(lcd_vs, e.vs, "R7 vs");
        chk(lcd_ld, e.ld, e.lmode ? "R9 ld valid" : "R8 ld width");
        chk(lcd_fr, e.fr, "R12 fr");
        chk(lcd_data, e.data, e.zero ? "R11 data forced" : "R10 data");
    endtask

    // monitor
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            if (q.size() != 0) begin
                e = q.pop_front();
                @(negedge clk);
                chk(lcd_pclk, e.pclk0, "R2 pclk first half");
                check_common(e);
                @(negedge clk);
                chk(lcd_pclk, e.pclk1, e.gate ? "R4 pclk gated" : "R3 pclk free");
                check_common(e);
            end
        end
    end

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    // stimulus
    initial begin
        cfg_drv = '0;
        cfg_drv.h_act = 10'd4; cfg_drv.h_blk = 10'd3;
        cfg_drv.v_act = 10'd3; cfg_drv.v_blk = 10'd3;
        cfg_drv.ld_width = 8'd2;
        repeat (3) @(negedge clk);
        idle_chk("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        cfg_drv.pol_pclk = 1'b1; cfg_drv.pol_hs = 1'b1;
        cfg_drv.pol_vs = 1'b1;   cfg_drv.pol_ld = 1'b1;
        repeat (2) @(negedge clk);
        idle_chk("R5 stopped polarity");
        cfg_drv.pol_pclk = 1'b0; cfg_drv.pol_hs = 1'b0;
        cfg_drv.pol_vs = 1'b0;   cfg_drv.pol_ld = 1'b0;
        repeat (2) @(negedge clk);

        // frame A: free clock, programmed load, hs polarity changed mid-frame
        restart();
        run_slots(10);
        cfg_drv.pol_hs = 1'b1; hold_tag = 1'b1;
        run_slots(32);
        hold_tag = 1'b0;
        run_slots(42);
        // frame B: gated clock, inverted polarities, width 2, load on valid
        cfg_drv.gate_clk = 1'b1; cfg_drv.pol_pclk = 1'b1;
        cfg_drv.pol_vs = 1'b1; cfg_drv.pol_ld = 1'b1;
        cfg_drv.vs_width = 2'b01; cfg_drv.ld_valid_mode = 1'b1;
        run_slots(42);
        // frame C: STN forces gating, width 3, forced zero data
        cfg_drv.gate_clk = 1'b0; cfg_drv.stn = 1'b1;
        cfg_drv.pol_pclk = 1'b0; cfg_drv.pol_vs = 1'b0; cfg_drv.pol_ld = 1'b0;
        cfg_drv.pol_hs = 1'b0; cfg_drv.vs_width = 2'b10;
        cfg_drv.data_zero = 1'b1; cfg_drv.ld_valid_mode = 1'b0;
        cfg_drv.ld_width = 8'd1;
        run_slots(42);
        // frames D: reserved width code, load truncated at line end
        cfg_drv.stn = 1'b0; cfg_drv.data_zero = 1'b0;
        cfg_drv.vs_width = 2'b11; cfg_drv.ld_width = 8'd5;
        run_slots(84);

        // stop with new idle polarities
        run = 1'b0; pix_vld = 1'b0;
        cfg_drv.pol_pclk = 1'b1; cfg_drv.pol_vs = 1'b1;
        repeat (3) @(negedge clk);
        idle_chk("R1 stopped");

        // restart with minimum blanking; vsync window clipped at frame end
        cfg_drv.pol_pclk = 1'b0; cfg_drv.pol_vs = 1'b0;
        cfg_drv.h_act = 10'd2; cfg_drv.h_blk = 10'd1;
        cfg_drv.v_act = 10'd1; cfg_drv.v_blk = 10'd2;
        cfg_drv.vs_width = 2'b10; cfg_drv.ld_width = 8'd0;
        repeat (2) @(negedge clk);
        restart();
        run_slots(18);
        run = 1'b0;
        repeat (4) @(negedge clk);
        if (q.size() != 0) chk(PIX_W'(q.size()), '0, "R2 scoreboard drained");
        finish_run();
    end

endmodule